// File: doc/BRIEF.md
# Secure-Gated APB Register Bank

This block is the completer side of an APB link. It holds a small bank of 32-bit registers. A requester writes and reads them through the usual setup and access phases. A write may set only some byte lanes, under per-lane strobes. Each transfer is stretched by a fixed number of wait cycles, set by a parameter, before ready rises.

Some registers are flagged secure-only by a parameter mask. A transfer marked non-secure that targets one of them ends with an error. Such a write changes nothing, and such a read returns zero. An unaligned address also ends with an error, and so does a word index beyond the bank. Outside the completing cycle, the error and read-data outputs are held at zero.

Control is a two-state machine. In `IDLE`, the block waits for a setup phase (select high, enable low). That phase takes it to `ACCESS` with the wait counter cleared. `ACCESS` stays in `ACCESS` while the counter runs. It returns to `IDLE` when the transfer completes (select, enable and ready all high), or when select drops.

Top module: `apb_secure_regbank`

## Requirements
- R1: After reset every register reads zero, and `pready`, `pslverr` and `prdata` are all low.
- R2: A write with all strobes set to byte address 4*i (i below NUM_REGS) stores the full word. A later read of that address returns it.
- R3: Strobe bit n enables write-data bits 8n+7..8n. Lanes whose strobe is low keep their previous contents.
- R4: `pready` rises only in the access phase, after exactly WAIT_CYCLES access cycles with it low (default 2). `pready` is low outside the access phase.
- R5: While an access phase waits with `pready` low, `prdata` is zero, `pslverr` is low, and no register changes.
- R6: An address with `paddr[1:0]` not zero completes with `pslverr` high. Such a write changes no register, and such a read returns zero.
- R7: An aligned address whose word index (`paddr[ADDR_W-1:2]`) is NUM_REGS or more completes with `pslverr` high and read data zero.
- R8: A register whose bit is set in SECURE_MASK (default registers 6 and 7, byte addresses 0x18 and 0x1C) rejects transfers with `pprot[1]`=1 (non-secure). A rejected transfer returns `pslverr` high, a write is ignored, and a read returns zero. With `pprot[1]`=0 it behaves as an ordinary register.
- R9: `pprot[0]` (privilege) and `pprot[2]` (instruction) have no effect on any transfer.
- R10: A transfer whose setup phase directly follows the completing cycle of the previous one is served normally, with the full wait count.
- R11: `pslverr` is high only in a completing cycle, and only for a rejected transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write enables |
| pprot | input | 3 | Protection: bit0 privileged, bit1 non-secure, bit2 instruction |
| prdata | output | DATA_W | Read data, zero outside a successful read completion |
| pready | output | 1 | Transfer completes when high in access phase |
| pslverr | output | 1 | Error, valid in the completing cycle only |

## Verification
The assertions check on every cycle that ready appears only inside an access phase. They also check that error appears only with ready, that read data and error stay zero while a transfer waits, and that the registers hold unless a commit is signalled. A further check is that a non-secure hit on a secure-only register always ends in an error. What the assertions cannot show comes from the bench's scenarios. These cover the exact wait count, the lane merging of strobed writes, and that rejected writes leave stored values intact. They also cover that the privilege and instruction bits are ignored, and that back-to-back transfers are served correctly.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } bank_state_e;
endpackage

// File: rtl/regbank_fsm.sv
module regbank_fsm
    import regbank_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic ready
);
    localparam int CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             count_done;

    assign count_done = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ready   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) begin
                    state_d = ST_ACCESS;
                    cnt_d   = '0;
                end
            end
            ST_ACCESS: begin
                if (!psel) begin
                    state_d = ST_IDLE;
                end else if (penable) begin
                    if (count_done) begin
                        ready   = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    a_r4_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (psel && penable && state_q == ST_ACCESS));

    a_r10_setup_enters_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && psel && !penable) |=> (state_q == ST_ACCESS && cnt_q == '0));
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int                    ADDR_W      = 8,
    parameter int                    NUM_REGS    = 8,
    parameter logic [NUM_REGS-1:0]   SECURE_MASK = 8'hC0
) (
    input  logic [ADDR_W-1:0]           paddr,
    input  logic                        non_secure,
    output logic [$clog2(NUM_REGS)-1:0] sel,
    output logic                        bad_align,
    output logic                        bad_range,
    output logic                        sec_reject,
    output logic                        reject
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] word_idx;
    logic             in_range;

    assign word_idx   = paddr[ADDR_W-1:2];
    assign bad_align  = (paddr[1:0] != 2'b00);
    assign in_range   = (word_idx < IDX_W'(NUM_REGS));
    assign bad_range  = !in_range;
    assign sel        = word_idx[SEL_W-1:0];
    assign sec_reject = in_range && non_secure && SECURE_MASK[sel];
    assign reject     = bad_align || bad_range || sec_reject;
endmodule

// File: rtl/regbank_storage.sv
module regbank_storage #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] sel,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W/8-1:0]         strb,
    output logic [DATA_W-1:0]           rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[r][8*b +: 8] <= 8'h00;
                end else if (wr_en && (int'(sel) == r) && strb[b]) begin
                    regs_q[r][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rdata = (int'(sel) < NUM_REGS) ? regs_q[sel] : '0;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hold_chk
        a_r5_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && int'(sel) == r) |=> $stable(regs_q[r]));
    end
endmodule

// File: rtl/apb_secure_regbank.sv
module apb_secure_regbank #(
    parameter int                  ADDR_W      = 8,
    parameter int                  DATA_W      = 32,
    parameter int                  NUM_REGS    = 8,
    parameter int                  WAIT_CYCLES = 2,
    parameter logic [NUM_REGS-1:0] SECURE_MASK = 8'hC0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    input  logic [DATA_W/8-1:0] pstrb,
    input  logic [2:0]          pprot,
    output logic [DATA_W-1:0]   prdata,
    output logic                pready,
    output logic                pslverr
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic             done;
    logic [SEL_W-1:0] sel;
    logic             bad_align, bad_range, sec_reject, reject;
    logic             wr_commit;
    logic [DATA_W-1:0] store_rdata;
    logic             unused_prot;

    assign unused_prot = pprot[0] ^ pprot[2];

    regbank_fsm #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .ready   (done)
    );

    regbank_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_REGS    (NUM_REGS),
        .SECURE_MASK (SECURE_MASK)
    ) u_decode (
        .paddr      (paddr),
        .non_secure (pprot[1]),
        .sel        (sel),
        .bad_align  (bad_align),
        .bad_range  (bad_range),
        .sec_reject (sec_reject),
        .reject     (reject)
    );

    assign wr_commit = done && pwrite && !reject;

    regbank_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_storage (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_commit),
        .sel   (sel),
        .wdata (pwdata),
        .strb  (pstrb),
        .rdata (store_rdata)
    );

    always_comb begin
        pready  = done;
        pslverr = done && reject;
        prdata  = (done && !pwrite && !reject) ? store_rdata : '0;
    end

    a_r11_err_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (pready && psel && penable));

    a_r5_quiet_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |-> (prdata == '0 && !pslverr));

    a_r8_secure_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && sec_reject) |-> (pslverr && prdata == '0));

    a_r6_misaligned_err: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && (bad_align || bad_range)) |-> pslverr);
endmodule

// File: tb/apb_secure_regbank_bench.sv
module apb_secure_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAITS      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [2:0]  pprot = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_secure_regbank #(.WAIT_CYCLES(WAITS)) u_apb_secure_regbank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
        .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic [2:0] p,
                        output logic [31:0] rd, output logic er,
                        output int waits, output logic quiet);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
        pwdata = d; pstrb = s; pprot = p;
        @(negedge clk);
        penable = 1'b1;
        #1;
        waits = 0; quiet = 1'b1;
        while (!pready && waits < 50) begin
            if (prdata != 0 || pslverr) quiet = 1'b0;
            waits++;
            @(negedge clk); #1;
        end
        rd = prdata; er = pslverr;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0; pstrb = '0; pprot = '0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic er, q; int w;
        chk("R1 pready", {31'b0, pready}, 0);
        chk("R1 pslverr", {31'b0, pslverr}, 0);
        chk("R1 prdata", prdata, 0);
        xfer(0, 8'h08, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R1 reg2 reset value", rd, 0);
    endtask

    task automatic t_full_write();
        logic [31:0] rd; logic er, q; int w;
        xfer(1, 8'h00, 32'hAABBCCDD, 4'hF, 3'b000, rd, er, w, q); bus_idle();
        chk("R2 write err", {31'b0, er}, 0);
        chk("R4 write wait count", w, WAITS);
        xfer(0, 8'h00, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R2 readback", rd, 32'hAABBCCDD);
        chk("R5 quiet while waiting", {31'b0, q}, 1);
        chk("R4 read wait count", w, WAITS);
    endtask

    task automatic t_strobe();
        logic [31:0] rd; logic er, q; int w;
        xfer(1, 8'h00, 32'h11223344, 4'b0101, 3'b000, rd, er, w, q); bus_idle();
        xfer(0, 8'h00, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R3 lanes 0,2 merged", rd, 32'hAA22CC44);
        xfer(1, 8'h00, 32'h99000000, 4'b1000, 3'b000, rd, er, w, q); bus_idle();
        xfer(0, 8'h00, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R3 lane 3 only", rd, 32'h9922CC44);
    endtask

    task automatic t_unaligned();
        logic [31:0] rd; logic er, q; int w;
        xfer(1, 8'h01, 32'h0BADF00D, 4'hF, 3'b000, rd, er, w, q); bus_idle();
        chk("R6 unaligned write err", {31'b0, er}, 1);
        xfer(0, 8'h02, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R6 unaligned read err", {31'b0, er}, 1);
        chk("R6 unaligned read data", rd, 0);
        xfer(0, 8'h00, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R6 reg0 unchanged", rd, 32'h9922CC44);
        chk("R11 no err on good read", {31'b0, er}, 0);
    endtask

    task automatic t_range();
        logic [31:0] rd; logic er, q; int w;
        xfer(0, 8'h20, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R7 out of range err", {31'b0, er}, 1);
        chk("R7 out of range data", rd, 0);
        xfer(1, 8'hFC, 32'h12345678, 4'hF, 3'b000, rd, er, w, q); bus_idle();
        chk("R7 far write err", {31'b0, er}, 1);
    endtask

    task automatic t_secure();
        logic [31:0] rd; logic er, q; int w;
        xfer(1, 8'h18, 32'hC0FFEE00, 4'hF, 3'b000, rd, er, w, q); bus_idle();
        chk("R8 secure write ok", {31'b0, er}, 0);
        xfer(1, 8'h18, 32'hDEADBEEF, 4'hF, 3'b010, rd, er, w, q); bus_idle();
        chk("R8 nonsecure write err", {31'b0, er}, 1);
        xfer(0, 8'h18, 0, 0, 3'b010, rd, er, w, q); bus_idle();
        chk("R8 nonsecure read err", {31'b0, er}, 1);
        chk("R8 nonsecure read zero", rd, 0);
        xfer(0, 8'h18, 0, 0, 3'b000, rd, er, w, q); bus_idle();
        chk("R8 secure read value", rd, 32'hC0FFEE00);
        xfer(1, 8'h14, 32'h55AA55AA, 4'hF, 3'b010, rd, er, w, q); bus_idle();
        chk("R8 nonsecure to open reg ok", {31'b0, er}, 0);
        xfer(0, 8'h14, 0, 0, 3'b010, rd, er, w, q); bus_idle();
        chk("R8 open reg readback", rd, 32'h55AA55AA);
    endtask

    task automatic t_prot_bits();
        logic [31:0] rd; logic er, q; int w;
        xfer(1, 8'h1C, 32'h0F0F1234, 4'hF, 3'b101, rd, er, w, q); bus_idle();
        chk("R9 priv+instr write ok", {31'b0, er}, 0);
        xfer(0, 8'h1C, 0, 0, 3'b001, rd, er, w, q); bus_idle();
        chk("R9 readback", rd, 32'h0F0F1234);
        chk("R9 read no err", {31'b0, er}, 0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] rd; logic er, q; int w;
        xfer(1, 8'h04, 32'h01020304, 4'hF, 3'b000, rd, er, w, q);
        xfer(1, 8'h08, 32'hA5A5A5A5, 4'hF, 3'b000, rd, er, w, q);
        chk("R10 second write wait count", w, WAITS);
        xfer(0, 8'h04, 0, 0, 3'b000, rd, er, w, q);
        chk("R10 b2b read reg1", rd, 32'h01020304);
        xfer(0, 8'h08, 0, 0, 3'b000, rd, er, w, q);
        chk("R10 b2b read reg2", rd, 32'hA5A5A5A5);
        chk("R10 b2b wait count", w, WAITS);
        bus_idle();
        #1;
        chk("R4 ready low when idle", {31'b0, pready}, 0);
        chk("R11 err low when idle", {31'b0, pslverr}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_strobe();
        t_unaligned();
        t_range();
        t_secure();
        t_prot_bits();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule